// File: doc/BRIEF.md
# Prescaled Down-Counter Timer with Watchdog Mode

This block is an 8-bit synchronous down counter that is advanced by an enable pulse from a programmable prescaler rather than by its own clock. Software picks one of sixteen tick rates, from 1 MHz down to 0.5 Hz when the block is clocked at 32 MHz, together with a reload value and an operating mode. The count runs down to zero and then signals a timeout.

There are three modes. In one-shot mode the block raises a single interrupt and then holds at zero. In periodic mode it reloads on the tick after zero and interrupts again on every pass. In watchdog mode a timeout pulls an active-low system-failure line. Software keeps that line high by writing the restart register before the count runs out. Once the line goes low it stays latched low until reset, or until software clears it with the watchdog stopped.

A small synchronous register port with one-cycle registered reads gives access to control, reload, the live count, status and restart. The interrupt output is the pending flag gated by an enable bit.

Top module: `pdc_timer`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x00, RELOAD (address 1) reads 0xFF, COUNT (address 2) reads 0, STATUS (address 3) reads 0, `irq_o` is low and `fail_n_o` is high.
- R2: CTRL holds mode in bits [1:0] (0 one-shot, 1 periodic, 2 watchdog, 3 behaves as one-shot), run in bit 2, interrupt enable in bit 3 and rate code in bits [7:4]. RELOAD and CTRL read back as written. A CTRL write that sets run while it was clear loads COUNT from RELOAD and restarts the prescaler. COUNT then drops by one per tick, and the k-th tick acts on the clock edge k*D+1 after the start write edge, where D is the prescaler divide ratio. Between ticks COUNT does not change.
- R3: The divide ratio is 32 times the tick period in microseconds. Rate codes 0 to 8 give 1 MHz, 500 kHz, 100 kHz, 10 kHz, 1 kHz, 100 Hz, 10 Hz, 1 Hz and 0.5 Hz, so codes 0, 1 and 2 divide by 32, 64 and 320. Codes 9 to 15 give periods of 4, 20, 200, 2000, 20000, 200000 and 500000 microseconds.
- R4: A timeout is the tick that takes COUNT from 1 to 0. In one-shot mode there is exactly one timeout, and COUNT then stays at 0.
- R5: In periodic mode the tick after COUNT reaches 0 reloads it. Every later timeout comes (RELOAD+1) ticks after the previous one.
- R6: With RELOAD equal to 0, no timeout occurs in any mode.
- R7: A timeout sets the pending flag (STATUS bit 0). Writing 1 to that bit clears it, and writing 0 leaves it alone. A timeout on the same edge as a clear write wins.
- R8: `irq_o` is high exactly when the pending flag and the enable bit are both set.
- R9: In watchdog mode a timeout drives `fail_n_o` low, and STATUS bit 1 reads 1. Writing any value to RESTART (address 4) reloads COUNT from RELOAD and restarts the prescaler, so regular restarts keep `fail_n_o` high.
- R10: `fail_n_o` stays low once set. A write of 1 to STATUS bit 1 clears it only while the watchdog is not running (run clear or mode not 2). Reset also clears it.
- R11: Clearing run stops the prescaler, so no tick occurs and COUNT freezes. Changing only the enable bit does not restart the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (32 MHz for the nominal rate table) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, data valid after the edge |
| addr | input | ADDR_W | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |
| fail_n_o | output | 1 | System-failure line, active low |

## Verification
The bench times the first and second interrupts to the exact cycle for random reload values and rate codes. A design off by one in the prescaler or the reload would move the edge by a cycle or by a whole tick. It aims a clear write at the very edge of a timeout, which a clear-wins design would lose. It also runs a zero reload, which a wrap-around counter would turn into a 256-tick timer. In watchdog mode it checks that restarts hold off expiry and that expiry lands exactly three ticks after the last restart. It then checks that a clear is refused while the watchdog runs, which a design with an unconditional clear would drop. Enable gating and the freeze on stop are checked through COUNT reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_WATCHDOG = 2'd2,
    MODE_RSVD     = 2'd3
  } tmr_mode_e;

  localparam int unsigned REG_CTRL    = 0;
  localparam int unsigned REG_RELOAD  = 1;
  localparam int unsigned REG_COUNT   = 2;
  localparam int unsigned REG_STATUS  = 3;
  localparam int unsigned REG_RESTART = 4;

  localparam int unsigned LONGEST_US = 2000000;

  // tick period in microseconds for each rate code
  function automatic int unsigned rate_period_us(input logic [3:0] code);
    case (code)
      4'd0:    return 1;
      4'd1:    return 2;
      4'd2:    return 10;
      4'd3:    return 100;
      4'd4:    return 1000;
      4'd5:    return 10000;
      4'd6:    return 100000;
      4'd7:    return 1000000;
      4'd8:    return 2000000;
      4'd9:    return 4;
      4'd10:   return 20;
      4'd11:   return 200;
      4'd12:   return 2000;
      4'd13:   return 20000;
      4'd14:   return 200000;
      default: return 500000;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned CLK_PER_US = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [3:0] rate,
  output logic       tick
);
  import tmr_pkg::*;

  localparam int unsigned MAX_DIV = CLK_PER_US * LONGEST_US;
  localparam int unsigned PRE_W   = $clog2(MAX_DIV);

  logic [PRE_W-1:0] div_cnt;
  logic [PRE_W-1:0] div_lim;

  always_comb begin
    div_lim = PRE_W'(CLK_PER_US * rate_period_us(rate) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (div_cnt == div_lim) begin
      div_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      tick    <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                load,
  input  logic [CNT_W-1:0]    reload,
  input  tmr_pkg::tmr_mode_e  mode,
  output logic [CNT_W-1:0]    cnt,
  output logic                timeout
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign timeout = tick && !load && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= reload;
    end else if (tick) begin
      if (cnt != '0) begin
        cnt <= cnt - ONE;
      end else if (mode == MODE_PERIODIC) begin
        cnt <= reload;
      end
    end
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int unsigned   CNT_W      = 8,
  parameter int unsigned   ADDR_W     = 3,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CNT_W-1:0]    wdata,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                timeout,
  output logic [CNT_W-1:0]    rdata,
  output tmr_pkg::tmr_mode_e  mode,
  output logic                run,
  output logic [3:0]          rate,
  output logic [CNT_W-1:0]    reload,
  output logic                load,
  output logic                presc_restart,
  output logic                pend,
  output logic                irq_o,
  output logic                fail_n_o
);
  import tmr_pkg::*;

  logic irq_en;
  logic fail_q;
  logic wr_ctrl, wr_reload, wr_status, wr_restart;
  logic wd_running;
  logic [CNT_W-1:0] rd_mux;

  assign wr_ctrl    = wr_en && (addr == ADDR_W'(REG_CTRL));
  assign wr_reload  = wr_en && (addr == ADDR_W'(REG_RELOAD));
  assign wr_status  = wr_en && (addr == ADDR_W'(REG_STATUS));
  assign wr_restart = wr_en && (addr == ADDR_W'(REG_RESTART));
  assign wd_running = run && (mode == MODE_WATCHDOG);

  assign load          = (wr_ctrl && wdata[2] && !run) || wr_restart;
  assign presc_restart = load || (wr_ctrl && (wdata[7:4] != rate));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_ONESHOT;
      run    <= 1'b0;
      irq_en <= 1'b0;
      rate   <= 4'd0;
      reload <= RELOAD_RST;
    end else begin
      if (wr_ctrl) begin
        mode   <= tmr_mode_e'(wdata[1:0]);
        run    <= wdata[2];
        irq_en <= wdata[3];
        rate   <= wdata[7:4];
      end
      if (wr_reload) reload <= wdata;
    end
  end

  // pending flag: set has priority over write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (timeout) begin
      pend <= 1'b1;
    end else if (wr_status && wdata[0]) begin
      pend <= 1'b0;
    end
  end

  // failure latch: clear refused while the watchdog runs
  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= 1'b0;
    end else if (timeout && (mode == MODE_WATCHDOG)) begin
      fail_q <= 1'b1;
    end else if (wr_status && wdata[1] && !wd_running) begin
      fail_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(REG_CTRL):   rd_mux[7:0] = {rate, irq_en, run, mode};
      ADDR_W'(REG_RELOAD): rd_mux = reload;
      ADDR_W'(REG_COUNT):  rd_mux = cnt;
      ADDR_W'(REG_STATUS): rd_mux[1:0] = {fail_q, pend};
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

  assign irq_o    = pend & irq_en;
  assign fail_n_o = ~fail_q;

endmodule

// File: rtl/pdc_timer.sv
module pdc_timer #(
  parameter int unsigned      CNT_W      = 8,
  parameter int unsigned      ADDR_W     = 3,
  parameter int unsigned      CLK_PER_US = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq_o,
  output logic              fail_n_o
);
  import tmr_pkg::*;

  tmr_mode_e        mode_w;
  logic             run_w;
  logic [3:0]       rate_w;
  logic [CNT_W-1:0] reload_w;
  logic             load_w;
  logic             presc_rst_w;
  logic             pend_w;
  logic             tick_w;
  logic [CNT_W-1:0] cnt_w;
  logic             timeout_w;

  tmr_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RELOAD_RST(RELOAD_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt_w), .timeout(timeout_w), .rdata(rdata),
    .mode(mode_w), .run(run_w), .rate(rate_w), .reload(reload_w),
    .load(load_w), .presc_restart(presc_rst_w), .pend(pend_w),
    .irq_o(irq_o), .fail_n_o(fail_n_o)
  );

  tmr_prescaler #(.CLK_PER_US(CLK_PER_US)) u_pre (
    .clk(clk), .rst(rst), .run(run_w), .restart(presc_rst_w),
    .rate(rate_w), .tick(tick_w)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick_w), .load(load_w), .reload(reload_w),
    .mode(mode_w), .cnt(cnt_w), .timeout(timeout_w)
  );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              load,
  input logic              timeout,
  input logic [CNT_W-1:0]  cnt,
  input logic              run,
  input logic [1:0]        mode,
  input logic              pend,
  input logic              fail_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata
);
  logic fail_clr_try;
  assign fail_clr_try = wr_en && (addr == ADDR_W'(3)) && wdata[1]
                        && !(run && (mode == 2'd2));

  assert_tick_gated_R11: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(run));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt));

  assert_oneshot_stuck_R4: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd0) && (cnt == '0) && !load) |=> (cnt == '0));

  assert_pend_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(timeout));

  assert_fail_origin_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(fail_n) |-> $past(timeout && (mode == 2'd2)));

  assert_fail_latched_R10: assert property (@(posedge clk) disable iff (rst)
    (!fail_n && !fail_clr_try) |=> !fail_n);

endmodule

bind pdc_timer tmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_w), .load(load_w), .timeout(timeout_w),
  .cnt(cnt_w), .run(run_w), .mode(mode_w), .pend(pend_w), .fail_n(fail_n_o),
  .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/pdc_timer_test.sv
module pdc_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_o;
  logic       fail_n_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  pdc_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fail_n_o(fail_n_o)
  );

  function automatic int div_of(input int code);
    case (code)
      0: return 32;
      1: return 64;
      default: return 320;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    rd_en = 1'b1; addr = 3'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic halt();
    wr(0, 8'h00);
    wr(3, 8'h03);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    cyc(4);
    rst = 1'b0;
    cyc(1);

    // R1 reset state
    check("R1 irq", irq_o, 0);
    check("R1 fail_n", fail_n_o, 1);
    rd(0, rv); check("R1 ctrl", rv, 8'h00);
    rd(1, rv); check("R1 reload", rv, 8'hFF);
    rd(2, rv); check("R1 count", rv, 0);
    rd(3, rv); check("R1 status", rv, 0);

    // R2 readback of control and reload
    wr(1, 8'h5A); rd(1, rv); check("R2 reload readback", rv, 8'h5A);
    wr(0, 8'h28); rd(0, rv); check("R2 ctrl readback", rv, 8'h28);
    halt();

    // R4 one-shot: reload 2, rate 0, enabled
    wr(1, 2);
    wr(0, 8'h0C);
    cyc(2*32);     check("R4 no early irq", irq_o, 0);
    cyc(1);        check("R4 irq at timeout", irq_o, 1);
    rd(2, rv);     check("R4 count zero", rv, 0);
    wr(3, 8'h01);  check("R7 cleared by W1C", irq_o, 0);
    cyc(300);      check("R4 single timeout", irq_o, 0);
    rd(2, rv);     check("R4 count held", rv, 0);
    halt();

    // R8 enable gating and R7 write-zero
    wr(1, 1);
    wr(0, 8'h04);
    cyc(40);       check("R8 gated off", irq_o, 0);
    rd(3, rv);     check("R7 pending set", rv & 1, 1);
    wr(0, 8'h0C);  check("R8 enable shows irq", irq_o, 1);
    wr(3, 8'h00);  check("R7 write zero keeps pend", irq_o, 1);
    halt();

    // R7 set wins over simultaneous clear (periodic, reload 2)
    wr(1, 2);
    wr(0, 8'h0D);
    cyc(64);
    wr(3, 8'h01);  check("R7 set wins", irq_o, 1);
    halt();

    // R6 zero reload never times out
    wr(1, 0);
    wr(0, 8'h0D);
    cyc(10*32);    check("R6 no irq", irq_o, 0);
    rd(2, rv);     check("R6 count zero", rv, 0);
    halt();

    // R11 freeze on stop, R2 decrement timing
    wr(1, 200);
    wr(0, 8'h0D);
    cyc(100);
    wr(0, 8'h09);
    rd(2, rv);     check("R2 count after 3 ticks", rv, 197);
    cyc(200);
    rd(2, rv);     check("R11 count frozen", rv, 197);
    halt();

    // R9 / R10 watchdog
    wr(1, 3);
    wr(0, 8'h06);
    for (int i = 0; i < 5; i++) begin
      cyc(60);
      wr(4, 8'hA5);
    end
    check("R9 restarts hold off", fail_n_o, 1);
    rd(2, rv);     check("R9 restart reloads", rv, 3);
    cyc(95);       check("R9 not yet expired", fail_n_o, 1);
    cyc(1);        check("R9 expiry drives low", fail_n_o, 0);
    wr(3, 8'h02);  check("R10 clear refused while running", fail_n_o, 0);
    rd(3, rv);     check("R9 status fail bit", (rv >> 1) & 1, 1);
    wr(0, 8'h02);  check("R10 latched after stop", fail_n_o, 0);
    wr(3, 8'h02);  check("R10 clear when stopped", fail_n_o, 1);
    halt();

    // R3 / R5 random periodic timing
    for (int t = 0; t < 8; t++) begin
      int n;
      int code;
      int d;
      n = 1 + int'($urandom % 8);
      code = int'($urandom % 3);
      d = div_of(code);
      wr(1, n);
      wr(0, (code << 4) | 8'h0D);
      cyc(n*d);       check("R3 first timeout not early", irq_o, 0);
      cyc(1);         check("R3 first timeout", irq_o, 1);
      wr(3, 8'h01);
      cyc((n+1)*d-2); check("R5 period not early", irq_o, 0);
      cyc(1);         check("R5 periodic timeout", irq_o, 1);
      halt();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule